// File: doc/BRIEF.md
# Multichannel Leading-Edge Photon Combiner

This block merges four single-bit detector sample streams into one parallel word stream for a downstream processor. Each stream carries one digitized sample per clock from one detector pixel. A photon shows up on a pixel as a run of consecutive high samples. Each channel has its own rising-edge detector, so that run is reduced to a single one-sample event placed on the first high sample.

The four event streams are then merged by OR into one serial stream. That serial stream is packed, sixteen samples at a time, into a parallel word. A one-cycle strobe marks each completed word, which cuts the rate seen by the consumer by a factor of sixteen. Edges are found before the merge. Pulses on different pixels may therefore overlap in time, and each still counts, as long as their first samples do not land on the same clock.

Top module: `photon_edge_combiner`

## Requirements
- R1: A channel that stays high for several consecutive samples contributes exactly one 1 to the merged stream, in the sample where it first goes high.
- R2: A channel that stays low, stays high, or falls from high to low contributes 0 in that sample. Only a low-to-high change between consecutive samples of the same channel counts as an event.
- R3: Each channel's history of its previous sample is 0 after reset. A channel that is already high in the first sample after reset therefore produces an event in that sample.
- R4: Each of the four channels (sample_in bits 0 to 3) is detected independently. An event on any single channel sets the merged bit for that sample.
- R5: Pulses on different channels that overlap in time produce one event each, provided their rising edges fall on different samples.
- R6: Rising edges on two or more channels in the same sample produce a single 1 in the merged stream. The loss is not reported.
- R7: Within a word, the first merged sample after a word boundary lands in word_out bit 0, and the sixteenth lands in bit 15.
- R8: word_valid is high for exactly one clock and then low for fifteen. It first rises on the clock after the sixteenth sample following reset has been registered. The completed word appears on word_out in that same cycle.
- R9: While rst is high (synchronous, active high), word_valid is 0 and word_out is 0. A new word boundary count then starts from the first sample after reset is released.
- R10: word_out holds its value in every cycle in which word_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per channel per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 4 | Digitized detector bits, bit i is pixel i |
| word_out | output | 16 | Packed merged events, oldest sample in bit 0 |
| word_valid | output | 1 | One-cycle strobe marking a newly completed word |

## Verification
The hardest case to reach is a sample whose merged bit depends on the exact previous value of every channel at once. Examples are a new rise on one pixel while another is still high, and two rises on the same clock. The bench reaches every such combination with a complete sweep over all ordered pairs of consecutive four-bit input values. The sweep is followed by a long pseudo-random stream, targeted overlapping and coincident pulses, an input that is high straight after reset, and a reset in mid-word. Every output is compared each cycle against an arithmetic model of the event bits and the word positions.

// File: rtl/pec_pkg.sv
package pec_pkg;

    localparam int PEC_NUM_CH = 4;
    localparam int PEC_WORD_W = 16;

    typedef logic [PEC_NUM_CH-1:0] ch_vec_t;

    // Leading edges for a vector of channels given their prior samples.
    function automatic ch_vec_t rise_of(input ch_vec_t cur, input ch_vec_t prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/pec_edge_bank.sv
module pec_edge_bank #(
    parameter int NUM_CH = pec_pkg::PEC_NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] sample_in,
    output logic [NUM_CH-1:0] rise_out
);

    logic [NUM_CH-1:0] hist_q;

    // One independent history flop and detector per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                hist_q[ch] <= 1'b0;
            end else begin
                hist_q[ch] <= sample_in[ch];
            end
        end
        assign rise_out[ch] = sample_in[ch] & ~hist_q[ch];
    end

endmodule

// File: rtl/pec_or_merge.sv
module pec_or_merge #(
    parameter int NUM_CH = pec_pkg::PEC_NUM_CH
) (
    input  logic [NUM_CH-1:0] rise_in,
    output logic              serial_out
);

    always_comb begin
        serial_out = 1'b0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            serial_out = serial_out | rise_in[ch];
        end
    end

endmodule

// File: rtl/pec_deser.sv
module pec_deser #(
    parameter int WORD_W = pec_pkg::PEC_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  pos_q;
    logic [WORD_W-1:0] accum_q;
    logic [WORD_W-1:0] accum_nxt;
    logic              at_last;

    assign at_last = (pos_q == LAST_POS);

    always_comb begin
        accum_nxt = accum_q;
        accum_nxt[pos_q] = serial_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q      <= '0;
            accum_q    <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= at_last;
            if (at_last) begin
                pos_q    <= '0;
                accum_q  <= '0;
                word_out <= accum_nxt;
            end else begin
                pos_q    <= pos_q + 1'b1;
                accum_q  <= accum_nxt;
            end
        end
    end

endmodule

// File: rtl/photon_edge_combiner.sv
module photon_edge_combiner #(
    parameter int NUM_CH = pec_pkg::PEC_NUM_CH,
    parameter int WORD_W = pec_pkg::PEC_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] sample_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    logic [NUM_CH-1:0] rise_vec;
    logic              serial_bit;

    pec_edge_bank #(.NUM_CH(NUM_CH)) u_edges (
        .clk       (clk),
        .rst       (rst),
        .sample_in (sample_in),
        .rise_out  (rise_vec)
    );

    pec_or_merge #(.NUM_CH(NUM_CH)) u_merge (
        .rise_in    (rise_vec),
        .serial_out (serial_bit)
    );

    pec_deser #(.WORD_W(WORD_W)) u_deser (
        .clk        (clk),
        .rst        (rst),
        .serial_in  (serial_bit),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
    parameter int NUM_CH = pec_pkg::PEC_NUM_CH,
    parameter int WORD_W = pec_pkg::PEC_WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] sample_in,
    input logic              serial_bit,
    input logic [WORD_W-1:0] word_out,
    input logic              word_valid
);

    logic       rst_q = 1'b1;
    logic [7:0] gap_q = '0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            gap_q <= '0;
        end else if (word_valid) begin
            gap_q <= 8'd1;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    // R1
    steady_no_event_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
        $stable(sample_in) |-> !serial_bit);

    // R4
    any_rise_event_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
        ((sample_in & ~$past(sample_in)) != '0) |-> serial_bit);

    // R2
    no_rise_no_event_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
        ((sample_in & ~$past(sample_in)) == '0) |-> !serial_bit);

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R8
    strobe_period_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid == (gap_q == 8'(WORD_W)));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!word_valid && word_out == '0));

    // R10
    word_hold_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
        !word_valid |-> $stable(word_out));

endmodule

bind photon_edge_combiner pec_checker #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_in  (sample_in),
    .serial_bit (serial_bit),
    .word_out   (word_out),
    .word_valid (word_valid)
);

// File: tb/photon_edge_combiner_tb.sv
module photon_edge_combiner_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int WW  = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] sample_in = '0;
    logic [WW-1:0]  word_out;
    logic           word_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model state
    logic [NCH-1:0] m_prev = '0;
    logic [WW-1:0]  m_acc  = '0;
    logic [WW-1:0]  m_word = '0;
    int             m_pos  = 0;
    logic           m_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    photon_edge_combiner u_dut (
        .clk        (clk),
        .rst        (rst),
        .sample_in  (sample_in),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [WW-1:0] act,
                         input logic [WW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(word_valid == m_valid, {tag, " R8 word_valid"}, WW'(word_valid), WW'(m_valid));
        check(word_out == m_word, {tag, " R7 R10 word_out"}, word_out, m_word);
    endtask

    // One sample: drive, clock, update model, compare away from the edge.
    task automatic step(input logic [NCH-1:0] v, input string tag);
        logic bit_m;
        sample_in = v;
        @(posedge clk);
        #1;
        bit_m = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (v[c] && !m_prev[c]) bit_m = 1'b1;
        end
        m_prev = v;
        m_acc[m_pos] = bit_m;
        if (m_pos == WW - 1) begin
            m_word  = m_acc;
            m_acc   = '0;
            m_pos   = 0;
            m_valid = 1'b1;
        end else begin
            m_pos   = m_pos + 1;
            m_valid = 1'b0;
        end
        compare(tag);
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            check(word_valid == 1'b0, "R9 valid in reset", WW'(word_valid), '0);
            check(word_out == '0, "R9 word in reset", word_out, '0);
        end
        rst = 1'b0;
        m_prev = '0; m_acc = '0; m_word = '0; m_pos = 0; m_valid = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr;
        sample_in = '0;
        do_reset(3);

        // R3: high right after reset, held a whole word (R1)
        for (int i = 0; i < WW; i++) step(4'b0001, "R3 R1 high-at-start");
        check(word_out == 16'h0001, "R3 R1 explicit word", word_out, 16'h0001);

        // R5: overlapping pulses, rises at 2,5,9 all fall at 12
        for (int i = 0; i < WW; i++) begin
            logic [NCH-1:0] v;
            v = '0;
            if (i >= 2 && i < 12) v[0] = 1'b1;
            if (i >= 5 && i < 12) v[1] = 1'b1;
            if (i >= 9 && i < 12) v[2] = 1'b1;
            step(v, "R5 overlap");
        end
        check(word_out == 16'h0224, "R5 explicit word", word_out, 16'h0224);

        // R6: coincident rises at sample 4, again at 10 on two channels
        for (int i = 0; i < WW; i++) begin
            logic [NCH-1:0] v;
            v = '0;
            if (i >= 4 && i < 7) v = 4'b1111;
            if (i >= 10 && i < 13) v = 4'b1010;
            step(v, "R6 coincident");
        end
        check(word_out == 16'h0410, "R6 explicit word", word_out, 16'h0410);

        // R7: single rise position k, per channel (R4)
        for (int k = 0; k < WW; k++) begin
            for (int i = 0; i < WW; i++) begin
                logic [NCH-1:0] v;
                v = (i == k) ? NCH'(1 << (k % NCH)) : '0;
                step(v, "R7 R4 bit position");
            end
            check(word_out == WW'(1 << k), "R7 explicit position", word_out, WW'(1 << k));
        end

        // R2 R4: exhaustive sweep of consecutive value pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(NCH'(a), "R2 R4 sweep");
                step(NCH'(b), "R2 R4 sweep");
            end
        end

        // R9: reset in mid-word restarts the boundary
        for (int i = 0; i < 7; i++) step(4'b0100, "R9 pre-reset");
        do_reset(1);
        for (int i = 0; i < 2 * WW; i++) step(NCH'(i % 3), "R9 post-reset");

        // Pseudo-random stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 40 * WW; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[NCH-1:0], "R1 R5 R6 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule